// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block computes the integer result of one register-register or register-immediate instruction of a classic 32-bit load/store RISC instruction set. It receives the two register operands, the 16-bit immediate, the 5-bit shift amount and the decoded opcode and function fields. It returns the result, a flag that requests an overflow exception, and a flag for encodings it does not recognise. The arithmetic is combinational. One output register stage lets a pipeline or a bench sample the result on a clock edge.

The unit covers the following operations:

- addition and subtraction, in trapping and non-trapping forms
- the bitwise AND, OR and NOR operations
- signed and unsigned set-less-than
- shifts by a constant amount
- the immediate forms, each of which extends its immediate in the way the instruction requires

Only the trapping add and subtract forms can raise the overflow flag.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result_q`, `ovf_trap_q` and `rsvd_q` are all zero at the next rising edge. After reset, every output reflects the inputs sampled at the previous rising edge of `clk`.
- R2: With `opcode`=0x00, the `funct` field selects the operation. funct 0x20 (add) and 0x21 (addu) return `op_a`+`op_b`. funct 0x22 (sub) and 0x23 (subu) return `op_a`-`op_b`. Results wrap modulo 2^32.
- R3: `ovf_trap_q` rises only for add (funct 0x20), sub (funct 0x22) and addi (opcode 0x08), when the signed result does not fit in 32 bits. The result is still the wrapped value. addu, subu, addiu and every other operation leave the flag at 0.
- R4: funct 0x24 returns `op_a & op_b`, funct 0x25 returns `op_a | op_b`, and funct 0x27 returns `~(op_a | op_b)`.
- R5: funct 0x2a writes 1 if `op_a` < `op_b` as signed numbers and 0 otherwise. funct 0x2b makes the same comparison with the operands taken as unsigned. Bits 31:1 are zero for both.
- R6: funct 0x00 shifts `op_b` left logically by `shamt`. funct 0x02 shifts `op_b` right logically by `shamt`. funct 0x03 shifts `op_b` right by `shamt` and fills the vacated bits with bit 31.
- R7: The immediates of addi (0x08), addiu (0x09), slti (0x0a) and sltiu (0x0b) are sign-extended: bit 15 is copied into bits 31:16. sltiu then compares the operands as unsigned numbers.
- R8: The immediates of andi (0x0c) and ori (0x0d) are zero-extended before the AND or OR with `op_a`.
- R9: lui (opcode 0x0f) returns the immediate in bits 31:16 and zero in bits 15:0.
- R10: Any other opcode, or any other funct with opcode 0x00, sets `rsvd_q`. In that case `result_q` is 0 and `ovf_trap_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Major opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| op_a | input | 32 | First register operand (rs) |
| op_b | input | 32 | Second register operand (rt) |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result_q | output | 32 | Registered result |
| ovf_trap_q | output | 1 | Registered overflow-exception request |
| rsvd_q | output | 1 | Registered unrecognised-encoding flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 16-bit immediate and a 5-bit shift amount. At these values the signed boundaries 0x7fffffff and 0x80000000 are directly reachable. The bench uses them to show where the trapping forms flag overflow and where the non-trapping forms do not. An immediate with bit 15 set separates sign extension from zero extension. It also reproduces the case where sltiu compares against an all-ones value.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DW    = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0] shamt,
  output logic [DW-1:0]   result_q,
  output logic            ovf_trap_q,
  output logic            rsvd_q
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] imm_sx, imm_zx, sum_rr, dif_rr, sum_ri;
  logic          ovf_add, ovf_sub, ovf_addi;
  logic [DW-1:0] res_d;
  logic          ovf_d, rsvd_d;

  assign imm_sx = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_zx = {{(DW-IMM_W){1'b0}}, imm};

  assign sum_rr = op_a + op_b;
  assign dif_rr = op_a - op_b;
  assign sum_ri = op_a + imm_sx;

  assign ovf_add  = (op_a[MSB] == op_b[MSB])   && (sum_rr[MSB] != op_a[MSB]);
  assign ovf_sub  = (op_a[MSB] != op_b[MSB])   && (dif_rr[MSB] != op_a[MSB]);
  assign ovf_addi = (op_a[MSB] == imm_sx[MSB]) && (sum_ri[MSB] != op_a[MSB]);

  always_comb begin
    res_d  = '0;
    ovf_d  = 1'b0;
    rsvd_d = 1'b0;
    case (opcode)
      6'h00: begin
        case (funct)
          6'h20: begin res_d = sum_rr; ovf_d = ovf_add; end
          6'h21: res_d = sum_rr;
          6'h22: begin res_d = dif_rr; ovf_d = ovf_sub; end
          6'h23: res_d = dif_rr;
          6'h24: res_d = op_a & op_b;
          6'h25: res_d = op_a | op_b;
          6'h27: res_d = ~(op_a | op_b);
          6'h2a: res_d = {{(DW-1){1'b0}}, $signed(op_a) < $signed(op_b)};
          6'h2b: res_d = {{(DW-1){1'b0}}, op_a < op_b};
          6'h00: res_d = op_b << shamt;
          6'h02: res_d = op_b >> shamt;
          6'h03: res_d = $unsigned($signed(op_b) >>> shamt);
          default: rsvd_d = 1'b1;
        endcase
      end
      6'h08: begin res_d = sum_ri; ovf_d = ovf_addi; end
      6'h09: res_d = sum_ri;
      6'h0a: res_d = {{(DW-1){1'b0}}, $signed(op_a) < $signed(imm_sx)};
      6'h0b: res_d = {{(DW-1){1'b0}}, op_a < imm_sx};
      6'h0c: res_d = op_a & imm_zx;
      6'h0d: res_d = op_a | imm_zx;
      6'h0f: res_d = {imm, {(DW-IMM_W){1'b0}}};
      default: rsvd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q   <= '0;
      ovf_trap_q <= 1'b0;
      rsvd_q     <= 1'b0;
    end else begin
      result_q   <= res_d;
      ovf_trap_q <= ovf_d;
      rsvd_q     <= rsvd_d;
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    opcode,
  input logic [5:0]    funct,
  input logic [DW-1:0] result_q,
  input logic          ovf_trap_q,
  input logic          rsvd_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result_q == '0 && !ovf_trap_q && !rsvd_q));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap_q |-> ($past(opcode) == 6'h08 ||
                    ($past(opcode) == 6'h00 &&
                     ($past(funct) == 6'h20 || $past(funct) == 6'h22))));

  a_r10_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_q |-> (result_q == '0 && !ovf_trap_q));

  a_r5_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (($past(opcode) == 6'h00 &&
      ($past(funct) == 6'h2a || $past(funct) == 6'h2b)) ||
      $past(opcode) == 6'h0a || $past(opcode) == 6'h0b))
    |-> (result_q[DW-1:1] == '0));

  a_r9_lui_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opcode) == 6'h0f) |-> (result_q[15:0] == '0 && !rsvd_q));
endmodule

bind int_exec_unit int_exec_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
  .result_q(result_q), .ovf_trap_q(ovf_trap_q), .rsvd_q(rsvd_q)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0, funct = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result_q;
  logic        ovf_trap_q, rsvd_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .op_a(op_a), .op_b(op_b), .imm(imm), .shamt(shamt),
    .result_q(result_q), .ovf_trap_q(ovf_trap_q), .rsvd_q(rsvd_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [5:0] opc, input logic [5:0] fn,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] im, input logic [4:0] sh);
    @(negedge clk);
    opcode = opc; funct = fn; op_a = a; op_b = b; imm = im; shamt = sh;
    @(negedge clk);
  endtask

  task automatic expect3(input string tag, input logic [31:0] r, input logic o, input logic rv);
    chk({tag, " result"}, result_q, r);
    chk({tag, " ovf"}, {31'b0, ovf_trap_q}, {31'b0, o});
    chk({tag, " rsvd"}, {31'b0, rsvd_q}, {31'b0, rv});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    run(6'h00, 6'h20, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
    expect3("R1 reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_addsub;
    run(6'h00, 6'h20, 32'h7fffffff, 32'h1, 0, 0); expect3("R2 R3 add ovf", 32'h80000000, 1, 0);
    run(6'h00, 6'h21, 32'h7fffffff, 32'h1, 0, 0); expect3("R3 addu no ovf", 32'h80000000, 0, 0);
    run(6'h00, 6'h20, 32'hffffffff, 32'hffffffff, 0, 0); expect3("R2 add neg", 32'hfffffffe, 0, 0);
    run(6'h00, 6'h22, 32'h80000000, 32'h1, 0, 0); expect3("R2 R3 sub ovf", 32'h7fffffff, 1, 0);
    run(6'h00, 6'h23, 32'h80000000, 32'h1, 0, 0); expect3("R3 subu no ovf", 32'h7fffffff, 0, 0);
    run(6'h00, 6'h22, 32'd5, 32'd3, 0, 0); expect3("R2 sub", 32'd2, 0, 0);
  endtask

  task automatic t_logic;
    run(6'h00, 6'h24, 32'hf0f0f0f0, 32'hff00ff00, 0, 0); expect3("R4 and", 32'hf000f000, 0, 0);
    run(6'h00, 6'h25, 32'hf0f0f0f0, 32'hff00ff00, 0, 0); expect3("R4 or", 32'hfff0fff0, 0, 0);
    run(6'h00, 6'h27, 32'hf0f0f0f0, 32'hff00ff00, 0, 0); expect3("R4 nor", 32'h000f000f, 0, 0);
  endtask

  task automatic t_slt;
    run(6'h00, 6'h2a, 32'hffffffff, 32'h1, 0, 0); expect3("R5 slt", 32'h1, 0, 0);
    run(6'h00, 6'h2b, 32'hffffffff, 32'h1, 0, 0); expect3("R5 sltu", 32'h0, 0, 0);
  endtask

  task automatic t_shift;
    run(6'h00, 6'h00, 0, 32'h80000001, 0, 5'd4); expect3("R6 sll", 32'h00000010, 0, 0);
    run(6'h00, 6'h02, 0, 32'h80000001, 0, 5'd4); expect3("R6 srl", 32'h08000000, 0, 0);
    run(6'h00, 6'h03, 0, 32'h80000001, 0, 5'd4); expect3("R6 sra", 32'hf8000000, 0, 0);
    run(6'h00, 6'h03, 0, 32'h40000000, 0, 5'd31); expect3("R6 sra pos", 32'h0, 0, 0);
  endtask

  task automatic t_signext;
    run(6'h08, 0, 32'd10, 0, 16'hffff, 0); expect3("R7 addi", 32'd9, 0, 0);
    run(6'h08, 0, 32'h7fffffff, 0, 16'h0001, 0); expect3("R3 addi ovf", 32'h80000000, 1, 0);
    run(6'h09, 0, 32'h7fffffff, 0, 16'h0001, 0); expect3("R3 addiu", 32'h80000000, 0, 0);
    run(6'h0a, 0, 32'h0, 0, 16'hffff, 0); expect3("R7 slti false", 32'h0, 0, 0);
    run(6'h0a, 0, 32'hfffffffe, 0, 16'hffff, 0); expect3("R7 slti true", 32'h1, 0, 0);
    run(6'h0b, 0, 32'd5, 0, 16'hffff, 0); expect3("R7 sltiu", 32'h1, 0, 0);
  endtask

  task automatic t_zeroext;
    run(6'h0c, 0, 32'hffffffff, 0, 16'h8001, 0); expect3("R8 andi", 32'h00008001, 0, 0);
    run(6'h0d, 0, 32'h0, 0, 16'h8000, 0); expect3("R8 ori", 32'h00008000, 0, 0);
  endtask

  task automatic t_lui;
    run(6'h0f, 0, 32'hffffffff, 0, 16'h1234, 0); expect3("R9 lui", 32'h12340000, 0, 0);
  endtask

  task automatic t_reserved;
    run(6'h00, 6'h01, 32'h7fffffff, 32'h1, 0, 0); expect3("R10 bad funct", 32'h0, 0, 1);
    run(6'h3f, 6'h20, 32'h7fffffff, 32'h1, 16'h1, 0); expect3("R10 bad opcode", 32'h0, 0, 1);
  endtask

  initial begin
    t_reset;
    t_addsub;
    t_logic;
    t_slt;
    t_shift;
    t_signext;
    t_zeroext;
    t_lui;
    t_reserved;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule